// File: doc/BRIEF.md
# Folded Radix-4 Inverse FFT, 64 Points

This block computes a 64-point inverse FFT on frames of complex fixed-point samples. It uses one radix-4 butterfly unit for every butterfly in the transform. A whole frame is taken in at once and stored in a 64-slot register array. A small controller then steps the butterfly through the array. On each cycle a 16-way selection picks four consecutive slots. The butterfly combines them with four constant twiddles, and the four results go back into the same slots. After the sixteenth group of a stage, the whole array is rewritten in a fixed reordered sequence. The controller repeats this for three stages.

Frames enter through a valid/ready handshake. The finished frame is presented through a second valid/ready handshake. The unit has three states. In `ST_IDLE` it waits, with ready asserted. Accepting a frame takes it to `ST_CRUNCH`, where it performs 48 butterfly steps. After the last group of stage 2 it moves to `ST_HOLD`, which keeps the result on the output. When the consumer accepts the result, it returns to `ST_IDLE`. Each stage divides by four, so the full transform carries the usual 1/64 inverse scaling.

Top module: `ifft64_folded`

## Requirements
- R1: While reset is held and right after it is released, `in_ready` is 1 and `out_valid` is 0.
- R2: `in_ready` is 1 only in `ST_IDLE`. A frame is taken at a rising edge where `in_valid` and `in_ready` are both 1. From that edge until the result is released, `in_ready` stays 0, even if `in_valid` is held high.
- R3: If a frame is accepted at edge A, `out_valid` is 0 after edges A+1 to A+47 and becomes 1 after edge A+48.
- R4: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` does not change.
- R5: After an edge where `out_valid` and `out_ready` are both 1, `out_valid` is 0 and `in_ready` is 1. A frame offered at that same edge is not taken, and is taken at the following edge.
- R6: Sample n of a frame uses bits [32n+31:32n] of the frame port. The signed real part is in the low 16 bits and the signed imaginary part is in the high 16 bits.
- R7: Twiddles are in Q1.14 format: round(16384·cos θ) and round(16384·sin θ), with θ = 2π·e/64. For stage s, group g and butterfly input j, e = (j · (g mod 4^s) · 4^(2−s)) mod 64. All twiddles in stage 0 are therefore 1.
- R8: Each twiddle product is computed at full precision, then arithmetically shifted right by 14 (rounding toward minus infinity). Results above 32767 or below −32768 saturate to that bound.
- R9: The butterfly forms y0=m0+m2, y1=m0−m2, y2=m1+m3 and y3=i·(m1−m3), where i·(a+ib) = −b+ia. It then forms z0=y0+y2, z1=y1+y3, z2=y0−y2 and z3=y1−y3, each arithmetically shifted right by 2 with no loss of range.
- R10: After the last group of every stage, including the final stage, slot n takes the value of slot 4·(n mod 16)+⌊n/16⌋.
- R11: Within a stage, groups run from 0 to 15 in order. Group g reads and writes slots 4g to 4g+3. Stages run from 0 to 2. The stage counter advances only after group 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An input frame is offered |
| in_ready | output | 1 | Unit is idle and will take a frame |
| in_data | input | 2048 | Input frame, 64 packed complex samples |
| out_valid | output | 1 | A finished frame is presented |
| out_ready | input | 1 | Consumer accepts the finished frame |
| out_data | output | 2048 | Transformed frame, same packing as the input |

## Verification
Releasing a finished frame and offering the next one can happen in the same cycle. The bench provokes this by raising `in_valid` with a new frame during the hold period, sometimes in the same cycle as `out_ready`. It then checks three things: the new frame is not taken while the result is held, the release edge leaves the unit idle, and the new frame is taken on the following edge and transforms correctly. The last butterfly write of a stage and the array reordering also share one edge. Every frame result is compared against a bench model that builds its twiddles from floating-point trigonometry. Directed all-full-scale frames drive the product saturation path.

// File: rtl/ifft_pkg.sv
package ifft_pkg;
    localparam int SAMP_W   = 16;
    localparam int N_PTS    = 64;
    localparam int RADIX    = 4;
    localparam int N_GROUPS = N_PTS / RADIX;
    localparam int N_STAGES = 3;
    localparam int TW_FRAC  = 14;
    localparam int GRP_W    = $clog2(N_GROUPS);
    localparam int STG_W    = $clog2(N_STAGES + 1);
    localparam int EXP_W    = $clog2(N_PTS);
    localparam int FRAME_W  = N_PTS * 2 * SAMP_W;

    typedef struct packed {
        logic signed [SAMP_W-1:0] im;
        logic signed [SAMP_W-1:0] re;
    } cplx_t;

    // First quadrant of the unit circle in Q1.14, index r gives cos(2*pi*r/64).
    function automatic logic signed [SAMP_W-1:0] quarter_cos(input logic [4:0] r);
        case (r)
            5'd0:    return 16'sd16384;
            5'd1:    return 16'sd16305;
            5'd2:    return 16'sd16069;
            5'd3:    return 16'sd15679;
            5'd4:    return 16'sd15137;
            5'd5:    return 16'sd14449;
            5'd6:    return 16'sd13623;
            5'd7:    return 16'sd12665;
            5'd8:    return 16'sd11585;
            5'd9:    return 16'sd10394;
            5'd10:   return 16'sd9102;
            5'd11:   return 16'sd7723;
            5'd12:   return 16'sd6270;
            5'd13:   return 16'sd4756;
            5'd14:   return 16'sd3196;
            5'd15:   return 16'sd1606;
            default: return 16'sd0;
        endcase
    endfunction

    // Root of unity exp(+j*2*pi*e/64) built from the quadrant table.
    function automatic cplx_t root_of_unity(input logic [EXP_W-1:0] e);
        logic [4:0] r;
        logic [4:0] rc;
        cplx_t      w;
        r  = {1'b0, e[3:0]};
        rc = 5'd16 - r;
        case (e[5:4])
            2'd0: begin w.re =  quarter_cos(r);  w.im =  quarter_cos(rc); end
            2'd1: begin w.re = -quarter_cos(rc); w.im =  quarter_cos(r);  end
            2'd2: begin w.re = -quarter_cos(r);  w.im = -quarter_cos(rc); end
            default: begin w.re = quarter_cos(rc); w.im = -quarter_cos(r); end
        endcase
        return w;
    endfunction

    // Exponent of the twiddle for input j of group g in stage s.
    function automatic logic [EXP_W-1:0] tw_exponent(input logic [1:0] s,
                                                     input logic [GRP_W-1:0] g,
                                                     input logic [1:0] j);
        logic [7:0] prod;
        case (s)
            2'd1:    prod = 8'(j) * 8'({g[1:0], 2'b00});
            2'd2:    prod = 8'(j) * 8'(g);
            default: prod = 8'd0;
        endcase
        return prod[EXP_W-1:0];
    endfunction

    // Source slot for destination slot n of the inter-stage reorder.
    function automatic int reorder_src(input int n);
        return (n % N_GROUPS) * RADIX + (n / N_GROUPS);
    endfunction
endpackage

// File: rtl/ifft_cmul.sv
module ifft_cmul #(
    parameter int DW   = 16,
    parameter int FRAC = 14
) (
    input  logic signed [DW-1:0] a_re,
    input  logic signed [DW-1:0] a_im,
    input  logic signed [DW-1:0] w_re,
    input  logic signed [DW-1:0] w_im,
    output logic signed [DW-1:0] p_re,
    output logic signed [DW-1:0] p_im
);
    localparam int AW = 2 * DW + 1;

    logic signed [AW-1:0] acc_re;
    logic signed [AW-1:0] acc_im;
    logic signed [AW-1:0] sh_re;
    logic signed [AW-1:0] sh_im;

    function automatic logic signed [DW-1:0] clip(input logic signed [AW-1:0] v);
        if (v[AW-1:DW-1] == '0 || v[AW-1:DW-1] == '1)
            return v[DW-1:0];
        else if (v[AW-1])
            return {1'b1, {(DW-1){1'b0}}};
        else
            return {1'b0, {(DW-1){1'b1}}};
    endfunction

    always_comb begin
        acc_re = (AW'(a_re) * AW'(w_re)) - (AW'(a_im) * AW'(w_im));
        acc_im = (AW'(a_re) * AW'(w_im)) + (AW'(a_im) * AW'(w_re));
        sh_re  = acc_re >>> FRAC;
        sh_im  = acc_im >>> FRAC;
        p_re   = clip(sh_re);
        p_im   = clip(sh_im);
    end
endmodule

// File: rtl/ifft_twiddle_gen.sv
module ifft_twiddle_gen
    import ifft_pkg::*;
(
    input  logic [1:0]       stage,
    input  logic [GRP_W-1:0] group,
    output cplx_t [RADIX-1:0] tw
);
    always_comb begin
        for (int j = 0; j < RADIX; j++) begin
            tw[j] = root_of_unity(tw_exponent(stage, group, 2'(j)));
        end
    end
endmodule

// File: rtl/ifft_bfly4.sv
module ifft_bfly4
    import ifft_pkg::*;
#(
    parameter int FRAC = TW_FRAC
) (
    input  cplx_t [RADIX-1:0] x_in,
    input  cplx_t [RADIX-1:0] w_in,
    output cplx_t [RADIX-1:0] z_out
);
    localparam int DW = SAMP_W;
    localparam int YW = DW + 2;

    logic signed [DW-1:0] m_re [RADIX];
    logic signed [DW-1:0] m_im [RADIX];
    logic signed [YW-1:0] y_re [RADIX];
    logic signed [YW-1:0] y_im [RADIX];
    logic signed [YW-1:0] z_re [RADIX];
    logic signed [YW-1:0] z_im [RADIX];
    logic signed [YW-1:0] d_re;
    logic signed [YW-1:0] d_im;

    for (genvar j = 0; j < RADIX; j++) begin : g_mul
        ifft_cmul #(.DW(DW), .FRAC(FRAC)) u_cmul (
            .a_re (x_in[j].re),
            .a_im (x_in[j].im),
            .w_re (w_in[j].re),
            .w_im (w_in[j].im),
            .p_re (m_re[j]),
            .p_im (m_im[j])
        );
    end

    always_comb begin
        y_re[0] = YW'(m_re[0]) + YW'(m_re[2]);
        y_im[0] = YW'(m_im[0]) + YW'(m_im[2]);
        y_re[1] = YW'(m_re[0]) - YW'(m_re[2]);
        y_im[1] = YW'(m_im[0]) - YW'(m_im[2]);
        y_re[2] = YW'(m_re[1]) + YW'(m_re[3]);
        y_im[2] = YW'(m_im[1]) + YW'(m_im[3]);
        d_re    = YW'(m_re[1]) - YW'(m_re[3]);
        d_im    = YW'(m_im[1]) - YW'(m_im[3]);
        // rotate by +90 degrees without a multiplier
        y_re[3] = -d_im;
        y_im[3] = d_re;
        z_re[0] = y_re[0] + y_re[2];
        z_im[0] = y_im[0] + y_im[2];
        z_re[1] = y_re[1] + y_re[3];
        z_im[1] = y_im[1] + y_im[3];
        z_re[2] = y_re[0] - y_re[2];
        z_im[2] = y_im[0] - y_im[2];
        z_re[3] = y_re[1] - y_re[3];
        z_im[3] = y_im[1] - y_im[3];
        for (int j = 0; j < RADIX; j++) begin
            z_out[j].re = z_re[j][YW-1:2];
            z_out[j].im = z_im[j][YW-1:2];
        end
    end
endmodule

// File: rtl/ifft64_folded.sv
module ifft64_folded
    import ifft_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [FRAME_W-1:0] in_data,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [FRAME_W-1:0] out_data
);
    localparam logic [GRP_W-1:0] LAST_GRP = GRP_W'(N_GROUPS - 1);
    localparam logic [1:0]       LAST_STG = 2'(N_STAGES - 1);

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_CRUNCH = 2'd1,
        ST_HOLD   = 2'd2
    } fsm_t;

    fsm_t st_q, st_d;

    logic [1:0]       stg_q;
    logic [GRP_W-1:0] grp_q;

    cplx_t [N_PTS-1:0] in_frame;
    cplx_t [N_PTS-1:0] arr_q;
    cplx_t [N_PTS-1:0] arr_wb;
    cplx_t [N_PTS-1:0] arr_perm;
    cplx_t [N_PTS-1:0] arr_d;
    cplx_t [RADIX-1:0] bf_x;
    cplx_t [RADIX-1:0] bf_w;
    cplx_t [RADIX-1:0] bf_z;

    logic load_en;
    logic step_en;
    logic grp_last;
    logic stg_last;

    assign in_frame = in_data;
    assign load_en  = (st_q == ST_IDLE) && in_valid;
    assign step_en  = (st_q == ST_CRUNCH);
    assign grp_last = (grp_q == LAST_GRP);
    assign stg_last = (stg_q == LAST_STG);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   if (in_valid)             st_d = ST_CRUNCH;
            ST_CRUNCH: if (grp_last && stg_last) st_d = ST_HOLD;
            ST_HOLD:   if (out_ready)            st_d = ST_IDLE;
            default:                             st_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        unique case (st_q)
            ST_IDLE:   in_ready  = 1'b1;
            ST_CRUNCH: ;
            ST_HOLD:   out_valid = 1'b1;
            default:   ;
        endcase
    end

    // group index and stage counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grp_q <= '0;
            stg_q <= '0;
        end else if (load_en) begin
            grp_q <= '0;
            stg_q <= '0;
        end else if (step_en) begin
            grp_q <= grp_q + 1'b1;
            if (grp_last) stg_q <= stg_last ? 2'd0 : stg_q + 2'd1;
        end
    end

    // single butterfly fed by a 16-way selection
    assign bf_x = arr_q[{grp_q, 2'b00} +: RADIX];

    ifft_twiddle_gen u_tw (
        .stage (stg_q),
        .group (grp_q),
        .tw    (bf_w)
    );

    ifft_bfly4 #(.FRAC(TW_FRAC)) u_bfly (
        .x_in  (bf_x),
        .w_in  (bf_w),
        .z_out (bf_z)
    );

    // 16-way return of results into the same four slots
    always_comb begin
        arr_wb = arr_q;
        arr_wb[{grp_q, 2'b00} +: RADIX] = bf_z;
    end

    for (genvar n = 0; n < N_PTS; n++) begin : g_slot
        assign arr_perm[n] = arr_wb[reorder_src(n)];
        always_comb begin
            if (load_en)       arr_d[n] = in_frame[n];
            else if (grp_last) arr_d[n] = arr_perm[n];
            else               arr_d[n] = arr_wb[n];
        end
    end

    always_ff @(posedge clk) begin
        if (load_en || step_en) arr_q <= arr_d;
    end

    assign out_data = arr_q;

    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (!in_ready && !out_valid && grp_q == '0 && stg_q == 2'd0)); // R2
    AST_GROUP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !grp_last) |=> (step_en && grp_q == $past(grp_q) + 1'b1 && stg_q == $past(stg_q))); // R11
    AST_STAGE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && grp_last && !stg_last) |=> (step_en && grp_q == '0 && stg_q == $past(stg_q) + 2'd1)); // R11
    AST_STAGE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        stg_q <= LAST_STG); // R11
    AST_LAST_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && grp_last && stg_last) |=> (out_valid && !in_ready)); // R3
    AST_HOLD_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R4
    AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |=> (!out_valid && in_ready)); // R5
endmodule

// File: tb/ifft64_folded_tb.sv
module ifft64_folded_tb_top;
    localparam int NPT  = 64;
    localparam int NFR  = 12;
    localparam real PI  = 3.14159265358979323846;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [2047:0] in_data = '0;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [2047:0] out_data;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    int cr [NPT];
    int ci [NPT];
    int er [NPT];
    int ei [NPT];

    always #2 clk = ~clk;

    ifft64_folded dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000 && !done) begin
            total++;
            bad++;
            $display("FAIL R3 watchdog: actual=%0d expected=<20000 cycles", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int sat16(input int v);
        if (v > 32767)  return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    function automatic int rnd(input real x);
        if (x >= 0.0) return int'($floor(x + 0.5));
        return -int'($floor(-x + 0.5));
    endfunction

    // reference transform built from the requirements (R7..R11)
    task automatic build_ref();
        int ar [NPT];
        int ai [NPT];
        int tr [NPT];
        int ti [NPT];
        int mr [4];
        int mi [4];
        int yr [4];
        int yi [4];
        for (int n = 0; n < NPT; n++) begin ar[n] = cr[n]; ai[n] = ci[n]; end
        for (int s = 0; s < 3; s++) begin
            for (int g = 0; g < 16; g++) begin
                for (int j = 0; j < 4; j++) begin
                    int e, wr, wi, xr, xi;
                    real ang;
                    e   = (j * (g % (4 ** s)) * (4 ** (2 - s))) % 64;
                    ang = 2.0 * PI * real'(e) / 64.0;
                    wr  = rnd(16384.0 * $cos(ang));
                    wi  = rnd(16384.0 * $sin(ang));
                    xr  = ar[4*g+j];
                    xi  = ai[4*g+j];
                    mr[j] = sat16((xr * wr - xi * wi) >>> 14);
                    mi[j] = sat16((xr * wi + xi * wr) >>> 14);
                end
                yr[0] = mr[0] + mr[2];  yi[0] = mi[0] + mi[2];
                yr[1] = mr[0] - mr[2];  yi[1] = mi[0] - mi[2];
                yr[2] = mr[1] + mr[3];  yi[2] = mi[1] + mi[3];
                yr[3] = -(mi[1] - mi[3]); yi[3] = mr[1] - mr[3];
                tr[4*g]   = (yr[0] + yr[2]) >>> 2;  ti[4*g]   = (yi[0] + yi[2]) >>> 2;
                tr[4*g+1] = (yr[1] + yr[3]) >>> 2;  ti[4*g+1] = (yi[1] + yi[3]) >>> 2;
                tr[4*g+2] = (yr[0] - yr[2]) >>> 2;  ti[4*g+2] = (yi[0] - yi[2]) >>> 2;
                tr[4*g+3] = (yr[1] - yr[3]) >>> 2;  ti[4*g+3] = (yi[1] - yi[3]) >>> 2;
            end
            for (int n = 0; n < NPT; n++) begin
                ar[n] = tr[(n % 16) * 4 + n / 16];
                ai[n] = ti[(n % 16) * 4 + n / 16];
            end
        end
        for (int n = 0; n < NPT; n++) begin er[n] = ar[n]; ei[n] = ai[n]; end
    endtask

    task automatic gen(input int kind);
        int spot;
        spot = int'($urandom % NPT);
        for (int n = 0; n < NPT; n++) begin
            case (kind)
                0: begin cr[n] = (n == 0) ? 1000 : 0; ci[n] = (n == 0) ? -500 : 0; end
                1: begin cr[n] = 32767; ci[n] = 32767; end
                2: begin cr[n] = -32768; ci[n] = -32768; end
                3: begin cr[n] = int'($signed(16'($urandom))); ci[n] = int'($signed(16'($urandom))); end
                4: begin cr[n] = int'($urandom % 2001) - 1000; ci[n] = int'($urandom % 2001) - 1000; end
                5: begin cr[n] = (n == spot) ? 20000 : 0; ci[n] = (n == spot) ? -7000 : 0; end
                default: begin cr[n] = n[0] ? -32768 : 32767; ci[n] = n[0] ? 32767 : -32768; end
            endcase
        end
    endtask

    // R6: sample n at [32n+31:32n], real low half, imaginary high half
    task automatic offer();
        for (int n = 0; n < NPT; n++) begin
            in_data[32*n +: 16]    = 16'(cr[n]);
            in_data[32*n+16 +: 16] = 16'(ci[n]);
        end
        in_valid = 1'b1;
    endtask

    // called at a falling edge with a frame already offered
    task automatic run_frame();
        bit lat_ok;
        int first_hi;
        int mism;
        chk(in_ready == 1'b1, "R2", "ready in idle", in_ready, 1);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        chk(!in_ready && !out_valid, "R2", "busy after accept", {in_ready, out_valid}, 0);
        lat_ok = 1'b1;
        first_hi = -1;
        for (int k = 1; k <= 48; k++) begin
            @(negedge clk);
            if (out_valid && first_hi < 0) first_hi = k;
            if (out_valid != (k == 48)) lat_ok = 1'b0;
        end
        chk(lat_ok, "R3", "edges until result", first_hi, 48);
        mism = 0;
        for (int n = 0; n < NPT; n++) begin
            int ar, ai;
            ar = int'($signed(out_data[32*n +: 16]));
            ai = int'($signed(out_data[32*n+16 +: 16]));
            if (ar != er[n] || ai != ei[n]) begin
                if (mism == 0)
                    $display("  first difference slot %0d: got (%0d,%0d) want (%0d,%0d)",
                             n, ar, ai, er[n], ei[n]);
                mism++;
            end
        end
        chk(mism == 0, "R6/R7/R8/R9/R10/R11", "mismatched samples", mism, 0);
    endtask

    task automatic finish_frame(input int hold, input int chain_kind);
        logic [2047:0] snap;
        bit ok;
        snap = out_data;
        ok = 1'b1;
        if (chain_kind >= 0) begin
            gen(chain_kind);
            build_ref();
            offer();
        end
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            if (!out_valid || out_data != snap) ok = 1'b0;
            if (in_ready) ok = 1'b0;
        end
        chk(ok, "R4", "result held while not accepted", ok, 1);
        out_ready = 1'b1;
        @(negedge clk);
        chk(!out_valid && in_ready, "R5", "idle after release", {out_valid, in_ready}, 1);
        out_ready = 1'b0;
    endtask

    function automatic int kind_of(input int i);
        return (i < 7) ? i : 3 + (i % 2);
    endfunction

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        chk(in_ready && !out_valid, "R1", "outputs during reset", {in_ready, out_valid}, 2);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready && !out_valid, "R1", "outputs after reset", {in_ready, out_valid}, 2);

        gen(kind_of(0));
        build_ref();
        offer();
        for (int it = 0; it < NFR; it++) begin
            bit chain;
            int nk;
            run_frame();
            nk = kind_of(it + 1);
            chain = (it % 3 == 1) && (it < NFR - 1);
            finish_frame((it == 4) ? 0 : int'($urandom % 4), chain ? nk : -1);
            if (!chain && it < NFR - 1) begin
                repeat (int'($urandom % 3)) @(negedge clk);
                gen(nk);
                build_ref();
                offer();
            end
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule